// File: doc/BRIEF.md
# Ring Frame Timing and Lock Monitor

This block watches the receive side of one ring of a cyclic, Ethernet-style field link. It times every frame, meaning the cycles during which the frame-valid input is high, and every idle gap between consecutive frames. Each measurement is compared against a nominal value held in a register, and a deviation beyond a fixed tolerance counts as an error. Frame, gap and packet-CRC errors feed three error counters. Each counter may advance only once per fixed time window, so a burst of faults cannot flood it.

A CRC failure on a timestamp packet is counted as a packet-CRC error. It also advances a run counter of timestamp failures. When that run reaches a programmable threshold, a sticky PLL-not-locked flag is raised, and it stays set until software clears it. A small register port holds the nominal lengths and the threshold. The same port reads the counters, the last measured lengths and the flag, and clears the counters.

The measuring engine has three states. `S_NOREF` is the state after reset or a link-up pulse, when no preceding frame end exists. `S_FRAME` means a frame is being timed. `S_GAP` means an idle gap is being timed. The transitions are:
- NOREF→FRAME on the first valid cycle.
- FRAME→GAP on a valid cycle carrying end-of-frame, or when valid drops without an end-of-frame marker.
- GAP→FRAME on the next valid cycle.
- Any state→NOREF on link-up, which has priority over all other transitions.

A gap is checked only on a GAP→FRAME transition, so the first gap after NOREF is never checked.

Top module: `ring_timing_monitor`

## Requirements
- R1: A frame's length is the number of valid cycles up to and including the cycle that carries end-of-frame (frames are at least 2 cycles long). It is readable at address 6 from the cycle after end-of-frame. A length differing from the nominal at address 0 by more than 16 cycles is a frame error, counted at address 3.
- R2: A gap's length is the number of non-valid cycles between end-of-frame and the next valid cycle. It is readable at address 7. A length differing from the nominal at address 1 by more than 32 cycles is a gap error, counted at address 4.
- R3: After reset or a link-up pulse, the gap before the next frame is neither checked nor stored.
- R4: Each error counter advances by at most one per window of WINDOW cycles, however many events occur in that window. The window counter starts at reset.
- R5: A packet-CRC strobe or a timestamp-CRC strobe advances the CRC error counter at address 5, subject to R4.
- R6: The threshold at address 2 resets to 32. A written 0 is stored as 1, and a written value above 128 is stored as 128. The not-locked flag sets when the run of timestamp-CRC errors reaches the threshold. A timestamp packet with good CRC resets the run to zero.
- R7: The not-locked flag is the output not_locked and bit 0 of address 8. It stays set until a write to address 8 with bit 0 set, and that write also resets the run.
- R8: Any write to addresses 3, 4 or 5 clears that counter to zero.
- R9: Error counters saturate at 2^CNT_W-1 and do not wrap.
- R10: After reset, all counters, lengths and nominals read 0, the threshold reads 32 and not_locked is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | High for each cycle of a received frame |
| frame_end | input | 1 | Marks the last valid cycle of a frame |
| pkt_crc_err | input | 1 | Strobe: packet failed CRC |
| ts_crc_err | input | 1 | Strobe: timestamp packet failed CRC |
| ts_crc_ok | input | 1 | Strobe: timestamp packet passed CRC |
| link_up | input | 1 | Strobe: link (re)established, timing reference lost |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from address) |
| not_locked | output | 1 | Sticky PLL-not-locked flag |

## Verification
Each result has a fixed latency after its stimulus. Stored lengths are readable one cycle after the closing edge. Frame and gap error counts appear two cycles after that edge, because the error pulse is registered before the counter. CRC counts and the not-locked flag update on the edge that samples the strobe. The bench drives inputs and samples reads at the falling edge, and waits at least three cycles before any read. It also aligns window-sensitive scenarios to a known offset of the window counter, so that each burst of events falls wholly inside one window.

// File: rtl/ring_mon_pkg.sv
package ring_mon_pkg;
    typedef enum logic [1:0] {
        S_NOREF = 2'd0,
        S_FRAME = 2'd1,
        S_GAP   = 2'd2
    } mon_state_t;

    localparam logic [3:0] A_NOM_FRAME = 4'd0;
    localparam logic [3:0] A_NOM_GAP   = 4'd1;
    localparam logic [3:0] A_THRESH    = 4'd2;
    localparam logic [3:0] A_CNT_BASE  = 4'd3;
    localparam logic [3:0] A_LAST_FRM  = 4'd6;
    localparam logic [3:0] A_LAST_GAP  = 4'd7;
    localparam logic [3:0] A_STATUS    = 4'd8;
endpackage

// File: rtl/rmon_len_fsm.sv
module rmon_len_fsm
    import ring_mon_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int TOL_FRM  = 16,
    parameter int TOL_GAP  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             frame_end,
    input  logic             link_up,
    input  logic [LEN_W-1:0] nom_frame,
    input  logic [LEN_W-1:0] nom_gap,
    output logic [LEN_W-1:0] last_frame,
    output logic [LEN_W-1:0] last_gap,
    output logic             frame_bad,
    output logic             gap_bad
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    mon_state_t       state, state_nx;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_inc;

    function automatic logic off_tol(input logic [LEN_W-1:0] len,
                                     input logic [LEN_W-1:0] nom,
                                     input int tol);
        logic [LEN_W-1:0] d;
        d = (len > nom) ? (len - nom) : (nom - len);
        return int'(d) > tol;
    endfunction

    assign cnt_inc = (cnt == LEN_MAX) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_NOREF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (link_up) begin
            state_nx = S_NOREF;
        end else begin
            unique case (state)
                S_NOREF: if (frame_valid) state_nx = S_FRAME;
                S_FRAME: if (!frame_valid || frame_end) state_nx = S_GAP;
                S_GAP:   if (frame_valid) state_nx = S_FRAME;
                default: state_nx = S_NOREF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            last_frame <= '0;
            last_gap   <= '0;
            frame_bad  <= 1'b0;
            gap_bad    <= 1'b0;
        end else begin
            frame_bad <= 1'b0;
            gap_bad   <= 1'b0;
            if (link_up) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    S_NOREF: if (frame_valid) cnt <= LEN_W'(1);
                    S_FRAME: begin
                        if (frame_valid && !frame_end) begin
                            cnt <= cnt_inc;
                        end else begin
                            last_frame <= frame_valid ? cnt_inc : cnt;
                            frame_bad  <= off_tol(frame_valid ? cnt_inc : cnt,
                                                  nom_frame, TOL_FRM);
                            cnt        <= '0;
                        end
                    end
                    S_GAP: begin
                        if (frame_valid) begin
                            last_gap <= cnt;
                            gap_bad  <= off_tol(cnt, nom_gap, TOL_GAP);
                            cnt      <= LEN_W'(1);
                        end else begin
                            cnt <= cnt_inc;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rmon_rate_cnt.sv
module rmon_rate_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_in,
    input  logic             win_tick,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            seen  <= 1'b0;
        end else begin
            seen <= win_tick ? 1'b0 : (seen | event_in);
            if (clr)
                count <= '0;
            else if (event_in && !seen && count != CNT_MAX)
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rmon_lock.sv
module rmon_lock #(
    parameter int MAX_THR = 128,
    parameter int DEF_THR = 32,
    parameter int WD_W    = 16,
    localparam int THR_W  = $clog2(MAX_THR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_err,
    input  logic             ts_ok,
    input  logic             thr_wr,
    input  logic             flag_clr,
    input  logic [WD_W-1:0]  wdata,
    output logic [THR_W-1:0] thresh,
    output logic             not_locked
);
    localparam logic [THR_W-1:0] RUN_MAX = '1;

    logic [THR_W-1:0] run;
    logic [THR_W-1:0] run_nx;

    assign run_nx = (run == RUN_MAX) ? run : run + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh     <= THR_W'(DEF_THR);
            run        <= '0;
            not_locked <= 1'b0;
        end else begin
            if (thr_wr) begin
                if (wdata == '0)                 thresh <= THR_W'(1);
                else if (int'(wdata) > MAX_THR)  thresh <= THR_W'(MAX_THR);
                else                             thresh <= THR_W'(wdata);
            end
            if (ts_err) begin
                run <= run_nx;
                if (run_nx >= thresh) not_locked <= 1'b1;
            end else if (ts_ok || flag_clr) begin
                run <= '0;
            end
            if (flag_clr && !ts_err) not_locked <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_timing_monitor.sv
module ring_timing_monitor
    import ring_mon_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int CNT_W   = 16,
    parameter int WINDOW  = 10000,
    parameter int TOL_FRM = 16,
    parameter int TOL_GAP = 32,
    parameter int MAX_THR = 128,
    parameter int DEF_THR = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             frame_end,
    input  logic             pkt_crc_err,
    input  logic             ts_crc_err,
    input  logic             ts_crc_ok,
    input  logic             link_up,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             not_locked
);
    localparam int WIN_W = $clog2(WINDOW);
    localparam int THR_W = $clog2(MAX_THR + 1);
    localparam int N_CNT = 3;

    logic [REG_W-1:0] nom_frame, nom_gap, last_frame, last_gap;
    logic             frame_bad, gap_bad;
    logic [WIN_W-1:0] win_cnt;
    logic             win_tick;
    logic [THR_W-1:0] thresh;
    logic [N_CNT-1:0] ev;
    logic [CNT_W-1:0] cnt_arr [N_CNT];
    logic [CNT_W-1:0] cnt_frame, cnt_gap, cnt_crc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nom_frame <= '0;
            nom_gap   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_NOM_FRAME) nom_frame <= reg_wdata;
            if (reg_addr == A_NOM_GAP)   nom_gap   <= reg_wdata;
        end
    end

    assign win_tick = (win_cnt == WIN_W'(WINDOW - 1));
    always_ff @(posedge clk) begin
        if (!rst_n)        win_cnt <= '0;
        else if (win_tick) win_cnt <= '0;
        else               win_cnt <= win_cnt + 1'b1;
    end

    rmon_len_fsm #(.LEN_W(REG_W), .TOL_FRM(TOL_FRM), .TOL_GAP(TOL_GAP)) len_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_end(frame_end),
        .link_up(link_up), .nom_frame(nom_frame), .nom_gap(nom_gap),
        .last_frame(last_frame), .last_gap(last_gap),
        .frame_bad(frame_bad), .gap_bad(gap_bad)
    );

    assign ev = {pkt_crc_err | ts_crc_err, gap_bad, frame_bad};

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        rmon_rate_cnt #(.CNT_W(CNT_W)) cnt_i (
            .clk(clk), .rst_n(rst_n), .event_in(ev[i]), .win_tick(win_tick),
            .clr(reg_wr && reg_addr == A_CNT_BASE + 4'(i)),
            .count(cnt_arr[i])
        );
    end
    assign cnt_frame = cnt_arr[0];
    assign cnt_gap   = cnt_arr[1];
    assign cnt_crc   = cnt_arr[2];

    rmon_lock #(.MAX_THR(MAX_THR), .DEF_THR(DEF_THR), .WD_W(REG_W)) lock_i (
        .clk(clk), .rst_n(rst_n), .ts_err(ts_crc_err), .ts_ok(ts_crc_ok),
        .thr_wr(reg_wr && reg_addr == A_THRESH),
        .flag_clr(reg_wr && reg_addr == A_STATUS && reg_wdata[0]),
        .wdata(reg_wdata), .thresh(thresh), .not_locked(not_locked)
    );

    always_comb begin
        unique case (reg_addr)
            A_NOM_FRAME: reg_rdata = nom_frame;
            A_NOM_GAP:   reg_rdata = nom_gap;
            A_THRESH:    reg_rdata = REG_W'(thresh);
            4'd3:        reg_rdata = REG_W'(cnt_frame);
            4'd4:        reg_rdata = REG_W'(cnt_gap);
            4'd5:        reg_rdata = REG_W'(cnt_crc);
            A_LAST_FRM:  reg_rdata = last_frame;
            A_LAST_GAP:  reg_rdata = last_gap;
            A_STATUS:    reg_rdata = REG_W'(not_locked);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rmon_checker.sv
module rmon_checker #(
    parameter int CNT_W   = 16,
    parameter int THR_W   = 8,
    parameter int MAX_THR = 128,
    parameter int REG_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_frame,
    input logic [CNT_W-1:0] cnt_crc,
    input logic             not_locked,
    input logic [THR_W-1:0] thresh,
    input logic             ts_crc_err,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r4_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_frame != $past(cnt_frame)) |->
            (cnt_frame == CNT_W'($past(cnt_frame) + 1'b1)) || (cnt_frame == '0));

    a_r4_crc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_crc != $past(cnt_crc)) |->
            (cnt_crc == CNT_W'($past(cnt_crc) + 1'b1)) || (cnt_crc == '0));

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_crc) == CMAX && cnt_crc != CMAX) |->
            $past(reg_wr && reg_addr == 4'd5));

    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_locked) |-> $past(ts_crc_err));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(not_locked) |-> $past(reg_wr && reg_addr == 4'd8 && reg_wdata[0]));

    a_r6_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(thresh) >= 1) && (int'(thresh) <= MAX_THR));
endmodule

bind ring_timing_monitor rmon_checker #(
    .CNT_W(CNT_W), .THR_W(THR_W), .MAX_THR(MAX_THR), .REG_W(REG_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt_frame(cnt_frame), .cnt_crc(cnt_crc),
    .not_locked(not_locked), .thresh(thresh), .ts_crc_err(ts_crc_err),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/ring_timing_monitor_tb_top.sv
module ring_timing_monitor_tb_top;
    localparam int W     = 400;
    localparam int CW    = 3;
    localparam int NOM_F = 100;
    localparam int NOM_G = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 0, frame_end = 0, pkt_crc_err = 0, ts_crc_err = 0;
    logic ts_crc_ok = 0, link_up = 0, reg_wr = 0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        not_locked;
    int errors = 0, checks = 0, cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    ring_timing_monitor #(.CNT_W(CW), .WINDOW(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_end(frame_end),
        .pkt_crc_err(pkt_crc_err), .ts_crc_err(ts_crc_err), .ts_crc_ok(ts_crc_ok),
        .link_up(link_up), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .not_locked(not_locked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, input int exp);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic frame(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            frame_valid = 1; frame_end = (i == len - 1);
        end
        @(negedge clk);
        frame_valid = 0; frame_end = 0;
    endtask

    // gap of g cycles: frame() already spent one low cycle
    task automatic gap(input int g);
        repeat (g - 1) @(negedge clk);
    endtask

    task automatic pulse_link;
        @(negedge clk); link_up = 1;
        @(negedge clk); link_up = 0;
    endtask

    task automatic align;
        @(negedge clk);
        while (cyc % W != 5) @(negedge clk);
    endtask

    task automatic t_reset;
        rd(4'd0, "R10", 0); rd(4'd1, "R10", 0); rd(4'd2, "R10", 32);
        rd(4'd3, "R10", 0); rd(4'd4, "R10", 0); rd(4'd5, "R10", 0);
        rd(4'd6, "R10", 0); rd(4'd7, "R10", 0); rd(4'd8, "R10", 0);
        check("R10 not_locked", int'(not_locked), 0);
    endtask

    task automatic t_in_tol;
        wr(4'd0, NOM_F); wr(4'd1, NOM_G);
        pulse_link;
        frame(100); gap(50); frame(116); gap(18); frame(84);
        idle(4);
        rd(4'd6, "R1 last frame", 84);
        rd(4'd7, "R2 last gap", 18);
        rd(4'd3, "R1 no frame err", 0);
        rd(4'd4, "R2 no gap err", 0);
    endtask

    task automatic t_out_tol;
        pulse_link;
        align;
        frame(117); gap(50); frame(83); gap(83); frame(100); gap(17); frame(100);
        idle(4);
        rd(4'd3, "R4 frame err once per window", 1);
        rd(4'd4, "R2 gap err two windows", 2);
        rd(4'd7, "R2 last gap", 17);
        pulse_link;
        idle(200);
        frame(100);
        idle(4);
        rd(4'd4, "R3 first gap unchecked", 2);
        rd(4'd7, "R3 first gap not stored", 17);
        wr(4'd3, 0);
        rd(4'd3, "R8 frame cnt cleared", 0);
        rd(4'd4, "R8 other cnt kept", 2);
    endtask

    task automatic t_crc;
        align;
        repeat (3) begin
            @(negedge clk); pkt_crc_err = 1;
            @(negedge clk); pkt_crc_err = 0;
        end
        idle(3);
        rd(4'd5, "R4 crc burst counts once", 1);
        align;
        @(negedge clk); ts_crc_err = 1;
        @(negedge clk); ts_crc_err = 0;
        idle(3);
        rd(4'd5, "R5 ts crc counts as crc", 2);
        wr(4'd5, 0);
        rd(4'd5, "R8 crc cleared", 0);
        for (int k = 0; k < 9; k++) begin
            align;
            @(negedge clk); pkt_crc_err = 1;
            @(negedge clk); pkt_crc_err = 0;
        end
        idle(3);
        rd(4'd5, "R9 saturates", 7);
        wr(4'd5, 0);
    endtask

    task automatic ts_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ts_crc_err = 1;
        end
        @(negedge clk); ts_crc_err = 0;
    endtask

    task automatic t_lock;
        wr(4'd8, 1);
        ts_burst(31);
        idle(2);
        check("R6 below threshold", int'(not_locked), 0);
        @(negedge clk); ts_crc_ok = 1;
        @(negedge clk); ts_crc_ok = 0;
        ts_burst(31);
        idle(2);
        check("R6 good ts resets run", int'(not_locked), 0);
        ts_burst(1);
        idle(2);
        check("R6 reach threshold 32", int'(not_locked), 1);
        idle(20);
        rd(4'd8, "R7 sticky", 1);
        wr(4'd8, 0);
        rd(4'd8, "R7 bit0 zero no clear", 1);
        wr(4'd8, 1);
        rd(4'd8, "R7 cleared", 0);
        wr(4'd2, 0);   rd(4'd2, "R6 clamp low", 1);
        wr(4'd2, 200); rd(4'd2, "R6 clamp high", 128);
        wr(4'd2, 3);
        ts_burst(2);
        idle(2);
        check("R6 thr3 two errors", int'(not_locked), 0);
        ts_burst(1);
        idle(2);
        check("R6 thr3 third error", int'(not_locked), 1);
        wr(4'd8, 1);
    endtask

    initial begin
        fork
            begin
                idle(3);
                @(negedge clk); rst_n = 1;
                idle(2);
                t_reset;
                t_in_tol;
                t_out_tol;
                t_crc;
                t_lock;
            end
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule